// File: doc/BRIEF.md
# Call Stack Trace Buffer

This block keeps a bounded record of the calls that a processor currently has open, so that a debugger can show where execution came from. The core signals a call with a one-cycle push strobe and a return with a one-cycle pop strobe. On a push the block stores the current program counter and the next program counter together as one pair. On a pop it forgets the newest pair by lowering its depth counter. Deciding which instructions are calls or returns is done outside this block.

A debugger reads the record through a word-addressed read port and sees how many pairs are live on a count output. Pair k sits at words 2k (program counter) and 2k+1 (next program counter). Once the record is full, further calls are dropped without wrapping, so the oldest and outermost frames are always kept.

Top module: `callstk_trace`

## Requirements
- R1: A push alone at depth n, with n below DEPTH, writes pc_i to word 2n and npc_i to word 2n+1, and depth_o reads n+1 after the clock edge.
- R2: A push alone when depth_o equals DEPTH is dropped: depth_o stays at DEPTH and no stored word changes.
- R3: A pop alone lowers depth_o by one when it is nonzero and has no effect at zero; popped words are not erased and still read back.
- R4: A push and a pop in the same cycle act as pop then push: at a nonzero depth n the pair at words 2(n-1) and 2(n-1)+1 is replaced and depth stays n; at depth zero the pair goes to words 0 and 1 and depth becomes 1.
- R5: Reset (rst_n low, asynchronous) forces depth_o and rdata_o to zero and leaves the stored words in place.
- R6: rdata_o is registered: it shows the word addressed by raddr_i one clock edge after raddr_i is presented, and a word written on that same edge is seen with its old value.
- R7: A read address of 2*DEPTH or above returns zero on rdata_o after one edge.
- R8: depth_o never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call strobe: store the pc/npc pair this cycle |
| pop_i | input | 1 | Return strobe: drop the newest pair this cycle |
| pc_i | input | WORD_W | Program counter stored on a push |
| npc_i | input | WORD_W | Next program counter stored on a push |
| raddr_i | input | RADDR_W | Word index for the debug read |
| rdata_o | output | WORD_W | Registered read data |
| depth_o | output | $clog2(DEPTH+1) | Number of live pairs |

## Verification
The assertions assume that push_i, pop_i and raddr_i carry known values on every rising edge while rst_n is high. Every mix of strobes is legal, and pc_i and npc_i only matter in cycles with a push. They also assume that RADDR_W is wide enough to name addresses past the last stored word, so that the zero-return case can occur at all. The bench changes every input on the falling edge and holds it through the next rising edge. It puts every strobe combination into the empty, partly filled and full states, and it uses read addresses both inside and outside the stored range.

// File: rtl/callstk_pkg.sv
package callstk_pkg;

  // Depth left after an optional pop (pop is applied first).
  function automatic int unsigned base_after_pop(int unsigned cnt, logic pop);
    return (pop && cnt != 0) ? cnt - 1 : cnt;
  endfunction

  // A pair fits only while the base is below capacity.
  function automatic logic has_room(int unsigned base, int unsigned depth);
    return base < depth;
  endfunction

  // Word index of one half of a pair.
  function automatic int unsigned pair_slot(int unsigned base, logic odd);
    return 2 * base + (odd ? 1 : 0);
  endfunction

endpackage

// File: rtl/callstk_ctl.sv
module callstk_ctl
  import callstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_base_o,
  output logic             pop_acc_o
);

  logic [CNT_W-1:0] count_q;
  int unsigned      base_u;
  logic             room;

  always_comb begin
    base_u = base_after_pop(32'(count_q), pop_i);
    room   = has_room(base_u, DEPTH);
  end

  assign wr_en_o   = push_i && room;
  assign wr_base_o = CNT_W'(base_u);
  assign pop_acc_o = pop_i && (count_q != '0);
  assign count_o   = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= CNT_W'(base_u + (wr_en_o ? 32'd1 : 32'd0));
    end
  end

endmodule

// File: rtl/callstk_store.sv
module callstk_store
  import callstk_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_base_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] npc_i,
  output logic [WORD_W-1:0] words_o [SLOTS]
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_word
    localparam logic ODD = (g % 2) == 1;
    logic [WORD_W-1:0] word_q;
    logic              hit;

    assign hit = wr_en_i && (pair_slot(32'(wr_base_i), ODD) == 32'(g));

    always_ff @(posedge clk) begin
      if (hit) begin
        word_q <= ODD ? npc_i : pc_i;
      end
    end

    assign words_o[g] = word_q;
  end

endmodule

// File: rtl/callstk_rdport.sv
module callstk_rdport #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned SLOTS   = 16,
  parameter int unsigned RADDR_W = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RADDR_W-1:0] raddr_i,
  input  logic [WORD_W-1:0]  words_i [SLOTS],
  output logic [WORD_W-1:0]  rdata_o
);

  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] sel;

  always_comb begin
    in_range = raddr_i < RADDR_W'(SLOTS);
    idx      = IDX_W'(raddr_i);
    sel      = in_range ? words_i[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= sel;
    end
  end

endmodule

// File: rtl/callstk_trace.sv
module callstk_trace #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned RADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [WORD_W-1:0]            pc_i,
  input  logic [WORD_W-1:0]            npc_i,
  input  logic [RADDR_W-1:0]           raddr_i,
  output logic [WORD_W-1:0]            rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o
);

  localparam int unsigned SLOTS = 2 * DEPTH;
  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic             wr_en;
  logic [CNT_W-1:0] wr_base;
  logic             pop_acc;
  logic [WORD_W-1:0] words [SLOTS];

  callstk_ctl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .count_o   (depth_o),
    .wr_en_o   (wr_en),
    .wr_base_o (wr_base),
    .pop_acc_o (pop_acc)
  );

  callstk_store #(
    .WORD_W (WORD_W),
    .SLOTS  (SLOTS),
    .CNT_W  (CNT_W)
  ) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_base_i (wr_base),
    .pc_i      (pc_i),
    .npc_i     (npc_i),
    .words_o   (words)
  );

  callstk_rdport #(
    .WORD_W  (WORD_W),
    .SLOTS   (SLOTS),
    .RADDR_W (RADDR_W),
    .IDX_W   (IDX_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr_i (raddr_i),
    .words_i (words),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/callstk_trace_chk.sv
module callstk_trace_chk #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned RADDR_W = 5,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               push_i,
  input logic               pop_i,
  input logic [RADDR_W-1:0] raddr_i,
  input logic [WORD_W-1:0]  rdata_o,
  input logic [CNT_W-1:0]   depth_o,
  input logic               wr_en,
  input logic               pop_acc
);

  localparam logic [CNT_W-1:0]   FULL   = CNT_W'(DEPTH);
  localparam logic [RADDR_W-1:0] TOP_RA = RADDR_W'(2 * DEPTH);

  p_push_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o != FULL) |=> depth_o == $past(depth_o) + CNT_W'(1));

  p_full_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o == FULL) |-> !wr_en);

  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o == FULL) |=> $stable(depth_o));

  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && depth_o != '0) |=> depth_o == $past(depth_o) - CNT_W'(1));

  p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && depth_o == '0) |=> depth_o == '0);

  p_pop_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |-> depth_o != '0);

  p_pair_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && depth_o != '0) |=> $stable(depth_o));

  p_pair_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && depth_o == '0) |=> depth_o == CNT_W'(1));

  p_oob_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_i >= TOP_RA) |=> rdata_o == '0);

  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= FULL);

endmodule

bind callstk_trace callstk_trace_chk #(
  .WORD_W  (WORD_W),
  .DEPTH   (DEPTH),
  .RADDR_W (RADDR_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .raddr_i (raddr_i),
  .rdata_o (rdata_o),
  .depth_o (depth_o),
  .wr_en   (wr_en),
  .pop_acc (pop_acc)
);

// File: tb/tb_callstk_trace.sv
module tb_callstk_trace;

  localparam int W  = 64;
  localparam int D  = 8;
  localparam int RA = 5;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [W-1:0]  pc_i = '0;
  logic [W-1:0]  npc_i = '0;
  logic [RA-1:0] raddr_i = '0;
  logic [W-1:0]  rdata_o;
  logic [CW-1:0] depth_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] mdl [2*D];
  int mcnt = 0;

  always #10 clk = ~clk;

  callstk_trace #(.WORD_W(W), .DEPTH(D), .RADDR_W(RA)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .pc_i(pc_i), .npc_i(npc_i), .raddr_i(raddr_i),
    .rdata_o(rdata_o), .depth_o(depth_o)
  );

  // Vector: {push, pop, seed[7:0], expected depth[3:0]}
  localparam int NV = 19;
  localparam logic [13:0] VEC [NV] = '{
    {2'b10, 8'h11, 4'd1}, {2'b10, 8'h12, 4'd2}, {2'b01, 8'h00, 4'd1},
    {2'b11, 8'h13, 4'd1}, {2'b01, 8'h00, 4'd0}, {2'b01, 8'h00, 4'd0},
    {2'b11, 8'h14, 4'd1}, {2'b10, 8'h15, 4'd2}, {2'b10, 8'h16, 4'd3},
    {2'b10, 8'h17, 4'd4}, {2'b10, 8'h18, 4'd5}, {2'b10, 8'h19, 4'd6},
    {2'b10, 8'h1A, 4'd7}, {2'b10, 8'h1B, 4'd8}, {2'b10, 8'h1C, 4'd8},
    {2'b11, 8'h1D, 4'd8}, {2'b01, 8'h00, 4'd7}, {2'b10, 8'h1E, 4'd8},
    {2'b00, 8'h00, 4'd8}
  };

  function automatic logic [W-1:0] mk_pc(logic [7:0] s);
    return {32'h8000_1000, 24'h0, s};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model: pop first, then push if room remains.
  task automatic model_op(logic pu, logic po, logic [W-1:0] p, logic [W-1:0] np);
    int base;
    base = (po && mcnt > 0) ? mcnt - 1 : mcnt;
    if (pu && base < D) begin
      mdl[2*base]   = p;
      mdl[2*base+1] = np;
      mcnt = base + 1;
    end else begin
      mcnt = base;
    end
  endtask

  task automatic read_chk(int idx, logic [W-1:0] exp, string req);
    @(negedge clk);
    raddr_i = RA'(idx);
    @(negedge clk);
    check(req, rdata_o, exp);
  endtask

  initial begin
    for (int i = 0; i < 2*D; i++) mdl[i] = '0;
    repeat (2) @(negedge clk);
    check("R5 reset depth", W'(depth_o), '0);
    check("R5 reset rdata", rdata_o, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic pu, po;
      logic [7:0] sd;
      string tag;
      pu = VEC[v][13];
      po = VEC[v][12];
      sd = VEC[v][11:4];
      if (pu && po) tag = "R4 push+pop depth";
      else if (po) tag = "R3 pop depth";
      else if (pu && mcnt == D) tag = "R2 full push depth";
      else tag = "R1 push depth";
      @(negedge clk);
      push_i = pu; pop_i = po;
      pc_i = mk_pc(sd); npc_i = mk_pc(sd) + 64'd4;
      model_op(pu, po, pc_i, npc_i);
      @(negedge clk);
      push_i = 1'b0; pop_i = 1'b0;
      check(tag, W'(depth_o), W'(VEC[v][3:0]));
      check("R8 model depth", W'(depth_o), W'(mcnt));
    end

    // Readback of all words against the model (R1, R2, R3, R4 storage).
    for (int k = 0; k < 2*D; k++) read_chk(k, mdl[k], "R1 R2 R4 readback");

    // R6: a word written on the read edge is seen with its old value.
    @(negedge clk);
    raddr_i = RA'(2*(D-1));
    push_i = 1'b1; pop_i = 1'b1;
    pc_i = mk_pc(8'h2F); npc_i = mk_pc(8'h2F) + 64'd4;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    check("R6 old value on write edge", rdata_o, mdl[2*(D-1)]);
    model_op(1'b1, 1'b1, pc_i, npc_i);
    @(negedge clk);
    check("R6 new value next edge", rdata_o, mk_pc(8'h2F));
    check("R4 full push+pop depth", W'(depth_o), W'(D));

    // R7: out-of-range reads return zero.
    read_chk(2*D, '0, "R7 first out-of-range");
    read_chk((1 << RA) - 1, '0, "R7 top address");

    // R3: popped words are kept.
    @(negedge clk); pop_i = 1'b1;
    @(negedge clk); pop_i = 1'b0;
    check("R3 pop from full", W'(depth_o), W'(D-1));
    read_chk(2*(D-1)+1, mk_pc(8'h2F) + 64'd4, "R3 popped word kept");

    // R5: reset mid-run clears depth and rdata, keeps storage.
    @(negedge clk);
    raddr_i = '0;
    rst_n = 1'b0;
    #1;
    check("R5 async reset depth", W'(depth_o), '0);
    check("R5 async reset rdata", rdata_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    read_chk(0, mdl[0], "R5 words survive reset");

    // R4 at zero depth: pair lands at words 0/1, depth becomes 1.
    @(negedge clk);
    push_i = 1'b1; pop_i = 1'b1;
    pc_i = mk_pc(8'h31); npc_i = mk_pc(8'h31) + 64'd4;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    check("R4 push+pop at empty", W'(depth_o), 64'd1);
    read_chk(1, mk_pc(8'h31) + 64'd4, "R4 npc at word 1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule